// File: doc/BRIEF.md
# Packed Decimal Adder

This block adds two unsigned decimal numbers held in packed binary-coded form, four bits per decimal digit, and produces their decimal sum, a carry out of the top digit and a flag that reports any operand digit outside the decimal range. It is purely combinational: the result follows the operands within the same cycle, and the surrounding logic registers it where the timing budget demands.

Every digit position (decade) runs two steps in series. First it adds its two operand digits and the carry from the decade below as plain binary numbers. Then it inspects that raw total: a total of ten or more gets six added to its low four bits and raises the carry into the next decade. Decade carries ripple upward from the external carry input, and the top decade's carry becomes the carry output. The number of decades is a parameter.

Top module: `bcd_adder`

## Requirements
- R1: A digit is the four-bit code 0000 to 1001 for values zero to nine; decade k occupies bits [4k+3:4k] of each operand and of the sum, decade 0 being the least significant.
- R2: With valid operands every sum digit is a legal code (value nine or less).
- R3: A decade whose raw total of digit a, digit b and incoming carry is ten or more (including raw totals of sixteen to nineteen, where the binary add itself overflows) outputs that total minus ten and passes a carry of 1 upward.
- R4: A decade whose raw total is nine or less outputs the raw total unchanged and passes a carry of 0 upward.
- R5: The carry into decade 0 is `carry_in`; the carry into every higher decade is the carry out of the decade below it.
- R6: For valid operands, the value of `carry_out` followed by `sum_bcd` read as a decimal number equals A + B + `carry_in`.
- R7: `code_error` is 1 whenever any digit of either operand holds one of the codes 1010 to 1111, in any decade; the sum outputs are then unspecified.
- R8: `code_error` is 0 whenever every digit of both operands is a legal code, including the all-nines operands.
- R9: A carry entering decade 0 propagates through every decade holding nine: 9999 + 0000 + 1 gives sum 0000 with `carry_out` 1 (four decades).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addend_a | input | 4*DIGITS | First packed decimal operand |
| addend_b | input | 4*DIGITS | Second packed decimal operand |
| carry_in | input | 1 | Decimal carry into decade 0 |
| sum_bcd | output | 4*DIGITS | Packed decimal sum |
| carry_out | output | 1 | Carry out of the most significant decade |
| code_error | output | 1 | An operand digit holds a forbidden code |

## Verification
Two functions meet in one decade when the correction step and an incoming decade carry coincide: a pair such as 9 and 9 with a carry arriving from below yields a raw total of nineteen, so the binary overflow path and the ripple must both be right. The bench provokes this with exhaustive single-decade pairs under both carry-in values, whose carry lands visibly in decade 1, and with all-nines operands, and judges each against a decimal model computed with integers. It also pairs forbidden digits in an upper decade with lower decades that generate carries, and judges only that the flag rises.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int NIB_W = 4;
  typedef logic [NIB_W-1:0] bcd_digit_t;
  typedef logic [NIB_W:0]   bcd_raw_t;
  localparam bcd_digit_t DEC_ADJUST = 4'd6;
endpackage

// File: rtl/bcd_bin_add4.sv
module bcd_bin_add4
  import bcd_pkg::*;
(
  input  bcd_digit_t op_a,
  input  bcd_digit_t op_b,
  input  logic       cin,
  output bcd_raw_t   raw
);
  assign raw = {1'b0, op_a} + {1'b0, op_b} + {{NIB_W{1'b0}}, cin};
endmodule

// File: rtl/bcd_fixup.sv
module bcd_fixup
  import bcd_pkg::*;
(
  input  bcd_raw_t   raw,
  output bcd_digit_t digit,
  output logic       carry
);
  logic need_fix;

  always_comb begin
    // ten or more: binary overflow, or 1x1x / 11xx in the low nibble
    need_fix = raw[NIB_W] | (raw[3] & (raw[2] | raw[1]));
    carry    = need_fix;
    if (need_fix) begin
      digit = raw[NIB_W-1:0] + DEC_ADJUST;
    end else begin
      digit = raw[NIB_W-1:0];
    end
  end
endmodule

// File: rtl/bcd_code_check.sv
module bcd_code_check
  import bcd_pkg::*;
(
  input  bcd_digit_t code,
  output logic       bad
);
  assign bad = code[3] & (code[2] | code[1]);
endmodule

// File: rtl/bcd_decade.sv
module bcd_decade
  import bcd_pkg::*;
(
  input  bcd_digit_t dig_a,
  input  bcd_digit_t dig_b,
  input  logic       cin,
  output bcd_digit_t dig_sum,
  output logic       cout
);
  bcd_raw_t raw_total;

  bcd_bin_add4 u_add (
    .op_a (dig_a),
    .op_b (dig_b),
    .cin  (cin),
    .raw  (raw_total)
  );

  bcd_fixup u_fix (
    .raw   (raw_total),
    .digit (dig_sum),
    .carry (cout)
  );
endmodule

// File: rtl/bcd_adder.sv
module bcd_adder
  import bcd_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int W = NIB_W * DIGITS
) (
  input  logic [W-1:0] addend_a,
  input  logic [W-1:0] addend_b,
  input  logic         carry_in,
  output logic [W-1:0] sum_bcd,
  output logic         carry_out,
  output logic         code_error
);
  logic [DIGITS:0]   dec_carry;
  logic [DIGITS-1:0] bad_a;
  logic [DIGITS-1:0] bad_b;

  assign dec_carry[0] = carry_in;

  for (genvar g = 0; g < DIGITS; g++) begin : g_decade
    bcd_decade u_dec (
      .dig_a   (addend_a[NIB_W*g +: NIB_W]),
      .dig_b   (addend_b[NIB_W*g +: NIB_W]),
      .cin     (dec_carry[g]),
      .dig_sum (sum_bcd[NIB_W*g +: NIB_W]),
      .cout    (dec_carry[g+1])
    );

    bcd_code_check u_chk_a (
      .code (addend_a[NIB_W*g +: NIB_W]),
      .bad  (bad_a[g])
    );

    bcd_code_check u_chk_b (
      .code (addend_b[NIB_W*g +: NIB_W]),
      .bad  (bad_b[g])
    );
  end

  assign carry_out  = dec_carry[DIGITS];
  assign code_error = |{bad_a, bad_b};
endmodule

// File: rtl/bcd_adder_chk.sv
module bcd_adder_chk #(
  parameter int DIGITS = 4,
  localparam int W = 4 * DIGITS
) (
  input logic [W-1:0]    addend_a,
  input logic [W-1:0]    addend_b,
  input logic            carry_in,
  input logic [W-1:0]    sum_bcd,
  input logic            carry_out,
  input logic            code_error,
  input logic [DIGITS:0] dec_carry
);
  always_comb begin
    for (int k = 0; k < DIGITS; k++) begin
      logic [4:0] in_tot;
      logic [4:0] out_tot;
      in_tot  = {1'b0, addend_a[4*k +: 4]} + {1'b0, addend_b[4*k +: 4]}
              + {4'd0, dec_carry[k]};
      out_tot = {1'b0, sum_bcd[4*k +: 4]} + (dec_carry[k+1] ? 5'd10 : 5'd0);
      if (!code_error) begin
        a_r2_digit_legal: assert (sum_bcd[4*k +: 4] <= 4'd9)
          else $error("R2 sum digit %0d out of range", k);
        a_r3_decade_total: assert (out_tot == in_tot)
          else $error("R3 decade %0d total mismatch", k);
        if (in_tot <= 5'd9) begin
          a_r4_no_fix: assert (!dec_carry[k+1] && sum_bcd[4*k +: 4] == in_tot[3:0])
            else $error("R4 decade %0d corrected without need", k);
        end
      end
      if (addend_a[4*k +: 4] > 4'd9 || addend_b[4*k +: 4] > 4'd9) begin
        a_r7_flag_raised: assert (code_error)
          else $error("R7 forbidden digit at decade %0d not flagged", k);
      end
    end
    if (code_error) begin
      a_r8_flag_cause: assert (addend_a > 0 || addend_b > 0)
        else $error("R8 flag raised on all-zero operands");
    end
    if (carry_out) begin
      a_r6_top_carry: assert (code_error || sum_bcd[W-4 +: 4] <= 4'd9)
        else $error("R6 carry out with illegal top digit");
    end
  end
endmodule

bind bcd_adder bcd_adder_chk #(.DIGITS(DIGITS)) u_bcd_chk (
  .addend_a   (addend_a),
  .addend_b   (addend_b),
  .carry_in   (carry_in),
  .sum_bcd    (sum_bcd),
  .carry_out  (carry_out),
  .code_error (code_error),
  .dec_carry  (dec_carry)
);

// File: tb/tb_bcd_adder.sv
module tb_bcd_adder;
  localparam int D = 4;
  localparam int W = 4 * D;
  localparam int MODULUS = 10000;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] op_a, op_b;
  logic         cin;
  logic [W-1:0] sum_o;
  logic         cout_o;
  logic         err_o;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  bcd_adder #(.DIGITS(D)) dut (
    .addend_a   (op_a),
    .addend_b   (op_b),
    .carry_in   (cin),
    .sum_bcd    (sum_o),
    .carry_out  (cout_o),
    .code_error (err_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [W-1:0] to_bcd(int v);
    logic [W-1:0] r = '0;
    for (int k = 0; k < D; k++) begin
      r[4*k +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  function automatic int from_bcd(logic [W-1:0] x);
    int v = 0;
    for (int k = D - 1; k >= 0; k--) v = v * 10 + int'(x[4*k +: 4]);
    return v;
  endfunction

  task automatic check_val(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  // drive after a rising edge, sample at the following falling edge
  task automatic apply_sum(string tag, logic [W-1:0] a, logic [W-1:0] b, logic c);
    int total;
    @(posedge clk);
    op_a = a; op_b = b; cin = c;
    @(negedge clk);
    total = from_bcd(a) + from_bcd(b) + int'(c);
    checks++;
    if (sum_o !== to_bcd(total % MODULUS) || cout_o !== (total >= MODULUS) || err_o !== 1'b0) begin
      failures++;
      $display("FAIL %s a=%h b=%h c=%0d got=%0d_%h err=%0d exp=%0d_%h err=0",
               tag, a, b, c, cout_o, sum_o, err_o, total >= MODULUS, to_bcd(total % MODULUS));
    end
  endtask

  initial begin
    rst_n = 1'b0;
    op_a = '0; op_b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // quiet state: zero operands give zero sum, no carry, no flag
    check_val("R8 idle flag", int'(err_o), 0);
    check_val("R6 idle sum", int'(sum_o), 0);
    check_val("R6 idle carry", int'(cout_o), 0);

    // R3 R4 R5: every single-decade pair, both carries; carry lands in decade 1
    for (int a = 0; a < 10; a++)
      for (int b = 0; b < 10; b++)
        for (int c = 0; c < 2; c++)
          apply_sum("R3_R4_R5 single decade", to_bcd(a), to_bcd(b), 1'(c));

    // R2 R6: random legal multi-decade operands against a decimal model
    for (int n = 0; n < 300; n++) begin
      apply_sum("R2_R6 random", to_bcd(int'($urandom_range(MODULUS - 1))),
                to_bcd(int'($urandom_range(MODULUS - 1))), 1'($urandom_range(1)));
    end

    // R9 full ripple and R8 all nines
    apply_sum("R9 ripple 9999+0+1", to_bcd(9999), to_bcd(0), 1'b1);
    apply_sum("R9 ripple 0+9999+1", to_bcd(0), to_bcd(9999), 1'b1);
    apply_sum("R8 all nines", to_bcd(9999), to_bcd(9999), 1'b1);
    apply_sum("R1 lane order", 16'h0001, 16'h1000, 1'b0);
    apply_sum("R5 mid chain", to_bcd(5050), to_bcd(4950), 1'b0);

    // R7: forbidden code in a random decade of either operand, lower decades carrying
    for (int n = 0; n < 120; n++) begin
      logic [W-1:0] a, b;
      int lane;
      a = to_bcd(int'($urandom_range(MODULUS - 1)));
      b = to_bcd(9999);
      lane = int'($urandom_range(D - 1));
      if (n % 2 == 0) a[4*lane +: 4] = 4'(10 + $urandom_range(5));
      else            b[4*lane +: 4] = 4'(10 + $urandom_range(5));
      @(posedge clk);
      op_a = a; op_b = b; cin = 1'b1;
      @(negedge clk);
      check_val("R7 forbidden digit flagged", int'(err_o), 1);
    end
    for (int code = 10; code < 16; code++) begin
      @(posedge clk);
      op_a = '0; op_b = 16'(code) << 12; cin = 1'b0;
      @(negedge clk);
      check_val("R7 top decade code", int'(err_o), 1);
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired got=timeout exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule